// File: doc/BRIEF.md
# Four-Lane 5x5 Convolution Engine

This block convolves a two-dimensional array of signed 16-bit samples with a 5x5 signed weight mask. It produces only interior points. Four output points that sit next to each other along the first (row) index are worked out together: four multiply-accumulate lanes each add one product per clock, so a group of four results is ready every 25 cycles. The 25 weights sit in a small local register file, loaded once while the engine is idle. Incoming samples go into a five-column sliding window, so every fetched sample serves up to five output columns without being fetched again. Each lane reads the window at a row offset equal to its own lane number, so one shared weight per step gives every lane its own convolution sum.

Samples arrive as packed groups of four words, which matches a memory that returns four 16-bit words per address. A frame of m rows by n columns is cut into horizontal bands of four output rows. For each band, the producer sends every column from left to right. Each column is two groups: the group holding rows 4g..4g+3, then the group holding rows 4g+4..4g+7. After the fifth column of a band, each further column starts one result group.

Top module: `conv5_engine`

## Requirements
- R1: After reset, `busy`, `done` and `res_valid` are low.
- R2: Each write on `wt_we` while idle stores `wt_data` at the next tap index, starting at 0 after reset and wrapping to 0 after index 24. Tap index t = 5*a + b holds the weight for row offset a-2 and column offset b-2 (row-major order), so a later full load of 25 writes replaces the earlier set.
- R3: Weight writes made while `busy` is high are ignored, and the results of the frame use the weights loaded before it.
- R4: A `start` pulse while idle latches `cfg_rows` (m, a multiple of 4 and at least 8) and `cfg_cols` (n, at least 5). `busy` is high from the next cycle. A `start` while busy is ignored.
- R5: Groups are taken only while a frame is being fed. Bits [16q+15:16q] of `grp_data` carry the sample at row h+q of the current column. For band g, the two groups of each column carry h=4g and then h=4g+4. `grp_valid` while idle has no effect.
- R6: Result lane q, in bits [40q+39:40q] of `res_sum`, is the signed sum over a,b in -2..2 of sample(res_row+q+a, res_col+b) times weight(a,b). It is exact in 40-bit two's complement.
- R7: Only interior points are reported. `res_row` = 2+4g, `res_col` runs from 2 to n-3, bands come in order and columns in order within a band, and a frame yields (m/4-1)*(n-4) result groups.
- R8: `res_valid` is a single-cycle pulse that rises exactly 25 cycles after the clock edge that takes the second group of a column with column index 4 or more.
- R9: Columns whose second groups are accepted 25 cycles apart are all processed, giving one result group per 25 cycles.
- R10: `done` pulses for one cycle, one cycle after the last result of the frame, and `busy` is low from that same cycle.
- R11: Full-scale samples and weights (-32768 everywhere) give a lane sum of 25*2^30 with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wt_we | input | 1 | Weight write strobe |
| wt_data | input | 16 | Signed weight written at the current tap index |
| cfg_rows | input | 8 | Frame row count m, latched at start |
| cfg_cols | input | 8 | Frame column count n, latched at start |
| start | input | 1 | Begin a frame (one-cycle pulse) |
| grp_valid | input | 1 | Sample group present |
| grp_data | input | 64 | Four packed signed samples, lane 0 in the low word |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| res_valid | output | 1 | One-cycle result strobe |
| res_row | output | 8 | Row index of result lane 0 |
| res_col | output | 8 | Column index of the result group |
| res_sum | output | 160 | Four packed signed 40-bit sums, lane 0 in the low bits |

## Verification
The bench uses the package defaults: 16-bit samples, 40-bit accumulators and 8-bit dimensions, with frames of up to 12 rows by 9 columns. The smallest legal frame (8 by 5) reaches the single-result case. A 12-row frame makes the band counter wrap and exercises the row offsets of the second band. Feeding at exactly 25-cycle spacing lets a new window load on the same edge as the previous result. Full-scale inputs bring the widest possible sum within reach of the 40-bit lanes.

// File: rtl/conv5_pkg.sv
package conv5_pkg;
  localparam int SMP_W  = 16;
  localparam int ACC_W  = 40;
  localparam int LANES  = 4;
  localparam int KS     = 5;
  localparam int TAPS   = KS * KS;
  localparam int WIN    = LANES + KS - 1;
  localparam int TAP_W  = $clog2(KS);
  localparam int TIDX_W = $clog2(TAPS);
  localparam int WIN_W  = $clog2(WIN);

  typedef logic signed [SMP_W-1:0] smp_t;
  typedef logic signed [ACC_W-1:0] acc_t;
  typedef logic [TAP_W-1:0]        tap_t;
  typedef logic [TIDX_W-1:0]       tidx_t;

  // one multiply-add step of a lane, both operands sign-extended first
  function automatic acc_t conv5_mac(input acc_t acc, input smp_t a, input smp_t b);
    acc_t pa;
    acc_t pb;
    pa = acc_t'(a);
    pb = acc_t'(b);
    return acc + pa * pb;
  endfunction

  // row-major tap index for row step kk and column step ll
  function automatic tidx_t conv5_tap(input tap_t kk, input tap_t ll);
    return tidx_t'(kk) * tidx_t'(KS) + tidx_t'(ll);
  endfunction
endpackage

// File: rtl/conv5_wstore.sv
module conv5_wstore
  import conv5_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we,
  input  smp_t  wdata,
  input  logic  lock,
  input  tidx_t rd_idx,
  output smp_t  rd_data
);
  logic [TAPS-1:0][SMP_W-1:0] w_q;
  tidx_t idx_q;
  logic  wr_ok;

  assign wr_ok   = we && !lock;
  assign rd_data = w_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q   <= '0;
      idx_q <= '0;
    end else if (wr_ok) begin
      w_q[idx_q] <= wdata;
      idx_q      <= (idx_q == tidx_t'(TAPS-1)) ? '0 : idx_q + 1'b1;
    end
  end

  // R3: a write while locked leaves index and contents untouched
  p_wt_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && lock) |=> ($stable(idx_q) && $stable(w_q)));

  // R2: tap index never leaves the 25-entry range
  p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < tidx_t'(TAPS));
endmodule

// File: rtl/conv5_window.sv
module conv5_window
  import conv5_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         acc_lo,
  input  logic                         acc_hi,
  input  logic                         load,
  input  logic [LANES-1:0][SMP_W-1:0]  grp,
  input  tap_t                         kk,
  input  tap_t                         ll,
  output logic [LANES-1:0][SMP_W-1:0]  smp_o
);
  logic [LANES-1:0][SMP_W-1:0]        lo_q;
  logic [KS-1:0][WIN-1:0][SMP_W-1:0]  win_q, win_d, snap_q;
  logic [WIN-1:0][SMP_W-1:0]          col_new;

  assign col_new = {grp, lo_q};

  always_comb begin
    for (int c = 0; c < KS - 1; c++) win_d[c] = win_q[c+1];
    win_d[KS-1] = col_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      win_q  <= '0;
      snap_q <= '0;
    end else begin
      if (acc_lo) lo_q <= grp;
      if (acc_hi) win_q <= win_d;
      if (load) snap_q <= win_d;
    end
  end

  // lane q reads row q+kk of column ll: the operand shifts across lanes per row step
  for (genvar q = 0; q < LANES; q++) begin : g_rd
    assign smp_o[q] = snap_q[ll][WIN_W'(q) + WIN_W'(kk)];
  end
endmodule

// File: rtl/conv5_lane.sv
module conv5_lane
  import conv5_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  input  smp_t smp,
  input  smp_t wgt,
  output acc_t sum_o
);
  acc_t acc_q;

  assign sum_o = conv5_mac(clr ? acc_t'(0) : acc_q, smp, wgt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (en) acc_q <= sum_o;
  end
endmodule

// File: rtl/conv5_seq.sv
module conv5_seq
  import conv5_pkg::*;
#(
  parameter int DIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             grp_valid,
  input  logic [DIM_W-1:0] cfg_rows,
  input  logic [DIM_W-1:0] cfg_cols,
  output logic             busy,
  output logic             acc_lo,
  output logic             acc_hi,
  output logic             load,
  output logic             run,
  output logic             first,
  output logic             fin,
  output tap_t             kk,
  output tap_t             ll,
  output logic [DIM_W-1:0] tag_row,
  output logic [DIM_W-1:0] tag_col,
  output logic             tag_last,
  output logic             done
);
  logic             feed_q, half_q, pend_q;
  logic [DIM_W-1:0] rows_q, cols_q, band_q, col_q;
  logic             col_end, band_end;

  assign acc_lo   = grp_valid && feed_q && !half_q;
  assign acc_hi   = grp_valid && feed_q && half_q;
  assign col_end  = (col_q == cols_q - 1'b1);
  assign band_end = ((band_q + DIM_W'(2)) == (rows_q >> 2));
  assign load     = acc_hi && (col_q >= DIM_W'(KS-1));
  assign first    = run && (kk == '0) && (ll == '0);
  assign fin      = run && (kk == tap_t'(KS-1)) && (ll == tap_t'(KS-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; feed_q <= 1'b0; half_q <= 1'b0; pend_q <= 1'b0; done <= 1'b0;
      rows_q <= '0; cols_q <= '0; band_q <= '0; col_q <= '0;
      run <= 1'b0; kk <= '0; ll <= '0;
      tag_row <= '0; tag_col <= '0; tag_last <= 1'b0;
    end else begin
      if (start && !busy) begin
        busy <= 1'b1; feed_q <= 1'b1; half_q <= 1'b0;
        band_q <= '0; col_q <= '0;
        rows_q <= cfg_rows; cols_q <= cfg_cols;
      end else begin
        if (acc_lo) half_q <= 1'b1;
        if (acc_hi) begin
          half_q <= 1'b0;
          if (col_end) begin
            col_q <= '0;
            if (band_end) feed_q <= 1'b0;
            else band_q <= band_q + 1'b1;
          end else begin
            col_q <= col_q + 1'b1;
          end
        end
        if (pend_q) busy <= 1'b0;
      end
      if (load) begin
        run <= 1'b1; kk <= '0; ll <= '0;
        tag_last <= band_end && col_end;
        tag_row  <= DIM_W'(2) + (band_q << 2);
        tag_col  <= col_q - DIM_W'(2);
      end else if (fin) begin
        run <= 1'b0;
      end else if (run) begin
        if (ll == tap_t'(KS-1)) begin
          ll <= '0;
          kk <= kk + 1'b1;
        end else begin
          ll <= ll + 1'b1;
        end
      end
      pend_q <= fin && tag_last;
      done   <= pend_q;
    end
  end

  // R4: a running accumulation implies a frame in progress
  p_run_busy_r4: assert property (@(posedge clk) disable iff (!rst_n) run |-> busy);
  // R5: groups are taken only inside a frame
  p_feed_busy_r5: assert property (@(posedge clk) disable iff (!rst_n) (acc_lo || acc_hi) |-> busy);
  // R8: step counters stay inside the 5x5 mask
  p_step_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (kk < tap_t'(KS) && ll < tap_t'(KS)));
endmodule

// File: rtl/conv5_engine.sv
module conv5_engine
  import conv5_pkg::*;
#(
  parameter int DIM_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wt_we,
  input  logic [SMP_W-1:0]         wt_data,
  input  logic [DIM_W-1:0]         cfg_rows,
  input  logic [DIM_W-1:0]         cfg_cols,
  input  logic                     start,
  input  logic                     grp_valid,
  input  logic [LANES*SMP_W-1:0]   grp_data,
  output logic                     busy,
  output logic                     done,
  output logic                     res_valid,
  output logic [DIM_W-1:0]         res_row,
  output logic [DIM_W-1:0]         res_col,
  output logic [LANES*ACC_W-1:0]   res_sum
);
  logic acc_lo, acc_hi, load, run, first, fin, tag_last;
  tap_t kk, ll;
  logic [DIM_W-1:0] tag_row, tag_col;
  smp_t wgt_cur;
  logic [LANES-1:0][SMP_W-1:0] lane_smp;
  acc_t lane_sum [LANES];

  logic                        res_valid_q;
  logic [DIM_W-1:0]            res_row_q, res_col_q;
  logic [LANES-1:0][ACC_W-1:0] res_sum_q;

  conv5_seq #(.DIM_W(DIM_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .grp_valid(grp_valid),
    .cfg_rows(cfg_rows), .cfg_cols(cfg_cols), .busy(busy),
    .acc_lo(acc_lo), .acc_hi(acc_hi), .load(load), .run(run), .first(first),
    .fin(fin), .kk(kk), .ll(ll), .tag_row(tag_row), .tag_col(tag_col),
    .tag_last(tag_last), .done(done)
  );

  conv5_wstore u_wst (
    .clk(clk), .rst_n(rst_n), .we(wt_we), .wdata(wt_data), .lock(busy),
    .rd_idx(conv5_tap(kk, ll)), .rd_data(wgt_cur)
  );

  conv5_window u_win (
    .clk(clk), .rst_n(rst_n), .acc_lo(acc_lo), .acc_hi(acc_hi), .load(load),
    .grp(grp_data), .kk(kk), .ll(ll), .smp_o(lane_smp)
  );

  for (genvar q = 0; q < LANES; q++) begin : g_lane
    conv5_lane u_lane (
      .clk(clk), .rst_n(rst_n), .en(run), .clr(first),
      .smp(lane_smp[q]), .wgt(wgt_cur), .sum_o(lane_sum[q])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid_q <= 1'b0;
      res_row_q   <= '0;
      res_col_q   <= '0;
      res_sum_q   <= '0;
    end else begin
      res_valid_q <= fin;
      if (fin) begin
        res_row_q <= tag_row;
        res_col_q <= tag_col;
        for (int q = 0; q < LANES; q++) res_sum_q[q] <= lane_sum[q];
      end
    end
  end

  assign res_valid = res_valid_q;
  assign res_row   = res_row_q;
  assign res_col   = res_col_q;
  assign res_sum   = res_sum_q;

  // R8: result strobe is a single-cycle pulse following the 25th product
  p_res_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n) res_valid |=> !res_valid);
  p_res_after_tap_r8: assert property (@(posedge clk) disable iff (!rst_n) res_valid |-> $past(fin));
  // R7: only interior coordinates are reported
  p_interior_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_row >= DIM_W'(2) && res_col >= DIM_W'(2)));
  // R10: done follows the last result and the engine is idle by then
  p_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(res_valid)));
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
endmodule

// File: tb/conv5_engine_tb_top.sv
module conv5_engine_tb_top;
  localparam int DW = 16;
  localparam int AW = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wt_we = 1'b0;
  logic [DW-1:0] wt_data = '0;
  logic [7:0] cfg_rows = '0, cfg_cols = '0;
  logic start = 1'b0, grp_valid = 1'b0;
  logic [4*DW-1:0] grp_data = '0;
  logic busy, done, res_valid;
  logic [7:0] res_row, res_col;
  logic [4*AW-1:0] res_sum;

  conv5_engine dut_i (
    .clk(clk), .rst_n(rst_n), .wt_we(wt_we), .wt_data(wt_data),
    .cfg_rows(cfg_rows), .cfg_cols(cfg_cols), .start(start),
    .grp_valid(grp_valid), .grp_data(grp_data), .busy(busy), .done(done),
    .res_valid(res_valid), .res_row(res_row), .res_col(res_col), .res_sum(res_sum)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  longint cyc = 0;
  bit all_done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic signed [15:0] fr [0:15][0:15];
  logic signed [15:0] wt [0:24];
  int     exp_row [0:63], exp_col [0:63];
  longint exp_t [0:63];
  int     r_exp, r_got, done_seen;
  longint last_res_cyc, done_cyc;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic longint model(input int i, input int j);
    longint s = 0;
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 5; b++)
        s += longint'(fr[i-2+a][j-2+b]) * longint'(wt[a*5+b]);
    return s;
  endfunction

  function automatic logic [63:0] pack(input int h, input int c);
    logic [63:0] d;
    for (int q = 0; q < 4; q++) d[q*16 +: 16] = fr[h+q][c];
    return d;
  endfunction

  // result monitor: coordinates (R7), timing (R8), lane sums (R6)
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (r_got < r_exp) begin
        chk(res_row == exp_row[r_got], "R7", "res_row", res_row, exp_row[r_got]);
        chk(res_col == exp_col[r_got], "R7", "res_col", res_col, exp_col[r_got]);
        chk(cyc == exp_t[r_got], "R8", "result cycle", cyc, exp_t[r_got]);
        for (int q = 0; q < 4; q++) begin
          longint got, expv;
          got  = longint'($signed(res_sum[q*AW +: AW]));
          expv = model(res_row + q, res_col);
          chk(got == expv, "R6", $sformatf("lane %0d sum", q), got, expv);
        end
      end else begin
        chk(1'b0, "R7", "unexpected result count", r_got + 1, r_exp);
      end
      r_got++;
      last_res_cyc = cyc;
    end
    if (rst_n && done) begin
      done_seen++;
      done_cyc = cyc;
    end
  end

  task automatic load_weights(input int kind);
    for (int t = 0; t < 25; t++) begin
      case (kind)
        0: wt[t] = 16'(t - 12);
        1: wt[t] = 16'((t / 5) * 7 - (t % 5) * 3 + 1);
        default: wt[t] = -16'sd32768;
      endcase
      @(negedge clk);
      wt_we = 1'b1; wt_data = wt[t];
    end
    @(negedge clk);
    wt_we = 1'b0;
  endtask

  task automatic fill_frame(input int kind);
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        case (kind)
          0: fr[i][j] = 16'(i * 16 + j - 100);
          1: fr[i][j] = 16'(((i * 37 + j * 11) % 200) - 100);
          default: fr[i][j] = -16'sd32768;
        endcase
  endtask

  task automatic run_frame(input int m, input int n, input int gap, input bit disturb);
    r_exp = 0; r_got = 0; done_seen = 0;
    @(negedge clk);
    cfg_rows = 8'(m); cfg_cols = 8'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R4", "busy after start", busy, 1);
    for (int g = 0; g < m / 4 - 1; g++) begin
      for (int c = 0; c < n; c++) begin
        grp_valid = 1'b1; grp_data = pack(4 * g, c);
        @(negedge clk);
        grp_data = pack(4 * g + 4, c);
        if (c >= 4) begin
          exp_row[r_exp] = 2 + 4 * g;
          exp_col[r_exp] = c - 2;
          exp_t[r_exp]   = cyc + 26;
          r_exp++;
        end
        @(negedge clk);
        grp_valid = 1'b0;
        if (disturb && g == 0 && c == 4) begin
          start = 1'b1; wt_we = 1'b1; wt_data = 16'h7fff;
          @(negedge clk);
          start = 1'b0; wt_we = 1'b0;
          repeat (gap - 1) @(negedge clk);
        end else begin
          repeat (gap) @(negedge clk);
        end
      end
    end
    for (int w = 0; w < 100 && done_seen == 0; w++) @(negedge clk);
    chk(r_got == r_exp, "R7", "result count", r_got, r_exp);
    chk(done_seen == 1, "R10", "done pulses", done_seen, 1);
    chk(done_cyc == last_res_cyc + 1, "R10", "done cycle", done_cyc, last_res_cyc + 1);
    chk(busy == 1'b0, "R10", "busy after done", busy, 0);
  endtask

  task automatic t_reset;
    chk(busy == 1'b0, "R1", "busy at reset", busy, 0);
    chk(done == 1'b0, "R1", "done at reset", done, 0);
    chk(res_valid == 1'b0, "R1", "res_valid at reset", res_valid, 0);
  endtask

  task automatic t_single;           // R2 R6 R7: smallest frame, one result
    load_weights(0); fill_frame(0);
    run_frame(8, 5, 26, 1'b0);
  endtask

  task automatic t_bands;            // R2 R7: two bands, asymmetric mask
    load_weights(1); fill_frame(1);
    run_frame(12, 8, 30, 1'b0);
  endtask

  task automatic t_rate;             // R9: second groups exactly 25 cycles apart
    load_weights(0); fill_frame(1);
    run_frame(8, 9, 23, 1'b0);
  endtask

  task automatic t_disturb;          // R3 R4: weight write and start while busy
    load_weights(1); fill_frame(0);
    run_frame(12, 6, 24, 1'b1);
  endtask

  task automatic t_idle_groups;      // R5: groups while idle change nothing
    fill_frame(1);
    r_got = 0; r_exp = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      grp_valid = 1'b1; grp_data = 64'hdead_beef_1234_5678;
    end
    @(negedge clk);
    grp_valid = 1'b0;
    repeat (30) @(negedge clk);
    chk(busy == 1'b0, "R5", "busy after idle groups", busy, 0);
    chk(r_got == 0, "R5", "results from idle groups", r_got, 0);
    run_frame(8, 6, 26, 1'b0);
  endtask

  task automatic t_reload;           // R2: a second full load replaces the first
    load_weights(1);
    load_weights(0); fill_frame(0);
    run_frame(8, 5, 26, 1'b0);
  endtask

  task automatic t_extreme;          // R11: full-scale operands
    load_weights(2); fill_frame(2);
    run_frame(8, 5, 26, 1'b0);
    chk(model(2, 2) == 64'sd26843545600, "R11", "model full-scale sum",
        model(2, 2), 64'sd26843545600);
  endtask

  initial begin
    r_exp = 0; r_got = 0; done_seen = 0; last_res_cyc = 0; done_cyc = 0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_single;
    t_bands;
    t_rate;
    t_disturb;
    t_idle_groups;
    t_reload;
    t_extreme;
    all_done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!all_done) begin
      n_chk++; n_bad++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule